// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block holds the control and status state of one descriptor-driven DMA channel. Software changes the state through a single control word. Bits 31:16 of that word form an enable mask, and bits 15:0 carry the new values. A status bit changes only when its enable bit is 1. The block also stores the channel's configuration words: command pointer, condition selects, transfer mode, second data pointer, and address extensions. All of them are readable over a simple word-addressed register bus.

A channel sequencer sits beside the block and reports events to it through single-cycle strobes and levels: activity, stop acknowledge, flush drained, fatal bus error, branch taken and device status. The sequencer reads the status bits and configuration words back from dedicated outputs.

Software stops a channel by clearing RUN and FLUSH together and polling until ACTIVE and FLUSH are both 0. It resets a channel by clearing RUN, PAUSE, FLUSH, WAKE, DEAD and ACTIVE together and then waiting for RUN to read 0.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset every status bit reads 0 and every configuration word reads 0.
- R2: The status bits sit at these positions: RUN 15, PAUSE 14, FLUSH 13, WAKE 12, DEAD 11, ACTIVE 10, branch-taken 8, device status 7:0. Bit 9 always reads 0. A write to word 0 changes status bit i to write-data bit i only if write-data bit i+16 is 1, and the change is visible on the next cycle.
- R3: A write to word 1 (status) changes nothing. Words 10, 13, 14 and 15 are reserved: they read 0 and ignore writes.
- R4: Words 2 to 9, 11 and 12 are 32-bit read/write configuration words. They appear on `cfgOut` as slots 0 to 9 in that address order, with slot k at bits 32k+31:32k.
- R5: A read of word 0 or word 1 returns the current status in bits 15:0, with zero in bits 31:16.
- R6: While RUN is 1 and PAUSE is 0, ACTIVE takes the value of `seqActive` on the next cycle. This overrides a software write to ACTIVE.
- R7: `seqStopAck` forces ACTIVE to 0 on the next cycle.
- R8: `seqFlushDone` clears FLUSH on the next cycle, even if the same cycle writes FLUSH to 1.
- R9: `seqFatal` sets DEAD and clears ACTIVE on the next cycle, whatever else happens in that cycle. DEAD then stays 1 until a masked write clears it.
- R10: `seqBtValid` loads branch-taken from `seqBt`, and `seqDevWe` loads the device status from `seqDevStat`. Each overrides a software write to the same bits in the same cycle.
- R11: The control word 0xA0000000 clears RUN and FLUSH and leaves the other bits alone. Once the sequencer drains and acknowledges, ACTIVE and FLUSH both read 0.
- R12: The control word 0xFC000000 clears RUN, PAUSE, FLUSH, WAKE, DEAD and ACTIVE in one cycle, and leaves branch-taken and device status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Word index (byte offset / 4) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| seqActive | input | 1 | Sequencer busy level |
| seqStopAck | input | 1 | Sequencer has stopped |
| seqFlushDone | input | 1 | Buffered data drained |
| seqFatal | input | 1 | Fatal bus error |
| seqBtValid | input | 1 | Load branch-taken bit |
| seqBt | input | 1 | Branch-taken value |
| seqDevWe | input | 1 | Load device status |
| seqDevStat | input | 8 | Device status value |
| statusOut | output | 16 | Current status bits |
| cfgOut | output | 320 | Configuration words, slot k at bits 32k+31:32k |

## Verification
The assertions check these properties on every cycle:
- the effect of a fatal error, a stop acknowledge and a drained flush one cycle later;
- that DEAD stays set;
- that ACTIVE follows the sequencer while running;
- that bit 9 stays 0;
- that reserved reads return 0;
- that status-word writes leave the software-owned bits and the configuration storage untouched.

Some behaviours only the bench's scenarios can show. These are the exact outcome of masked writes with partial masks, the priority of sequencer loads over software writes in the same cycle, the full stop and reset handshakes as software polls them, and the address order of the configuration slots. The bench's cycle model covers all of them.

// File: rtl/dma_csr_pkg.sv
`timescale 1ns/1ps
package dma_csr_pkg;
  localparam int REG_W    = 32;
  localparam int HALF_W   = REG_W / 2;
  localparam int ADDR_W   = 4;
  localparam int NUM_CFG  = 10;
  localparam int SLOT_W   = $clog2(NUM_CFG);
  localparam int DEV_W    = 8;

  // status bit positions
  localparam int B_RUN    = 15;
  localparam int B_PAUSE  = 14;
  localparam int B_FLUSH  = 13;
  localparam int B_WAKE   = 12;
  localparam int B_DEAD   = 11;
  localparam int B_ACTIVE = 10;
  localparam int B_BT     = 8;

  // implemented status bits (bit 9 is held at zero)
  localparam logic [HALF_W-1:0] STAT_IMPL = 16'hFDFF;

  // word indices whose position is decoded by software
  localparam logic [ADDR_W-1:0] W_CTL  = 4'd0;
  localparam logic [ADDR_W-1:0] W_STAT = 4'd1;

  typedef enum logic [1:0] {
    AC_CTL,
    AC_STAT,
    AC_CFG,
    AC_RSVD
  } addrClass_t;

  typedef struct packed {
    logic               ctlWr;
    logic [HALF_W-1:0]  wrMask;
    logic [HALF_W-1:0]  wrVal;
    logic               cfgWr;
    logic [SLOT_W-1:0]  cfgSlot;
    logic               trackActive;
    logic               activeVal;
    logic               killActive;
    logic               setDead;
    logic               clrFlush;
    logic               btLoad;
    logic               btVal;
    logic               devLoad;
    logic [DEV_W-1:0]   devVal;
  } csrStrobes_t;

  function automatic addrClass_t classifyAddr(input logic [ADDR_W-1:0] a);
    if (a == W_CTL) return AC_CTL;
    if (a == W_STAT) return AC_STAT;
    if ((a >= 4'd2 && a <= 4'd9) || a == 4'd11 || a == 4'd12) return AC_CFG;
    return AC_RSVD;
  endfunction

  // words 2..9 -> slots 0..7, word 11 -> slot 8, word 12 -> slot 9
  function automatic logic [SLOT_W-1:0] slotOf(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] s;
    if (a >= 4'd11) s = a - 4'd3;
    else            s = a - 4'd2;
    return s[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/dma_csr_ctrl.sv
`timescale 1ns/1ps
module dma_csr_ctrl
  import dma_csr_pkg::*;
(
  input  logic                       regWe,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [REG_W-1:0]           regWdata,
  input  logic                       runQ,
  input  logic                       pauseQ,
  input  logic                       seqActive,
  input  logic                       seqStopAck,
  input  logic                       seqFlushDone,
  input  logic                       seqFatal,
  input  logic                       seqBtValid,
  input  logic                       seqBt,
  input  logic                       seqDevWe,
  input  logic [DEV_W-1:0]           seqDevStat,
  output csrStrobes_t                str
);
  addrClass_t addrClass;

  always_comb begin
    addrClass       = classifyAddr(regAddr);
    str             = '0;
    str.ctlWr       = regWe && (addrClass == AC_CTL);
    str.wrMask      = regWdata[REG_W-1:HALF_W] & STAT_IMPL;
    str.wrVal       = regWdata[HALF_W-1:0];
    str.cfgWr       = regWe && (addrClass == AC_CFG);
    str.cfgSlot     = slotOf(regAddr);
    str.trackActive = runQ && !pauseQ;
    str.activeVal   = seqActive;
    str.killActive  = seqStopAck || seqFatal;
    str.setDead     = seqFatal;
    str.clrFlush    = seqFlushDone;
    str.btLoad      = seqBtValid;
    str.btVal       = seqBt;
    str.devLoad     = seqDevWe;
    str.devVal      = seqDevStat;
  end
endmodule

// File: rtl/dma_csr_datapath.sv
`timescale 1ns/1ps
module dma_csr_datapath
  import dma_csr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  csrStrobes_t                str,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [REG_W-1:0]           regWdata,
  output logic [REG_W-1:0]           regRdata,
  output logic [HALF_W-1:0]          statusQ,
  output logic [NUM_CFG*REG_W-1:0]   cfgFlat
);
  logic [HALF_W-1:0] statusNxt;
  logic [REG_W-1:0]  cfgQ [NUM_CFG];
  logic [REG_W-1:0]  cfgRd;

  // next status: software write first, sequencer events override in order
  always_comb begin
    statusNxt = statusQ;
    if (str.ctlWr)       statusNxt = (statusQ & ~str.wrMask) | (str.wrVal & str.wrMask);
    if (str.devLoad)     statusNxt[DEV_W-1:0] = str.devVal;
    if (str.btLoad)      statusNxt[B_BT] = str.btVal;
    if (str.clrFlush)    statusNxt[B_FLUSH] = 1'b0;
    if (str.trackActive) statusNxt[B_ACTIVE] = str.activeVal;
    if (str.killActive)  statusNxt[B_ACTIVE] = 1'b0;
    if (str.setDead)     statusNxt[B_DEAD] = 1'b1;
    statusNxt = statusNxt & STAT_IMPL;
  end

  always_ff @(posedge clk) begin
    if (rst) statusQ <= '0;
    else     statusQ <= statusNxt;
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : gCfg
    always_ff @(posedge clk) begin
      if (rst) cfgQ[g] <= '0;
      else if (str.cfgWr && (str.cfgSlot == SLOT_W'(g))) cfgQ[g] <= regWdata;
    end
    assign cfgFlat[g*REG_W +: REG_W] = cfgQ[g];
  end

  always_comb begin
    cfgRd = '0;
    for (int k = 0; k < NUM_CFG; k++)
      if (slotOf(regAddr) == SLOT_W'(k)) cfgRd = cfgQ[k];
  end

  always_comb begin
    unique case (classifyAddr(regAddr))
      AC_CTL, AC_STAT: regRdata = {{(REG_W-HALF_W){1'b0}}, statusQ};
      AC_CFG:          regRdata = cfgRd;
      default:         regRdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_csr.sv
`timescale 1ns/1ps
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int CFG_WORDS = NUM_CFG,
  parameter int DEVW      = DEV_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          regWe,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [REG_W-1:0]              regWdata,
  output logic [REG_W-1:0]              regRdata,
  input  logic                          seqActive,
  input  logic                          seqStopAck,
  input  logic                          seqFlushDone,
  input  logic                          seqFatal,
  input  logic                          seqBtValid,
  input  logic                          seqBt,
  input  logic                          seqDevWe,
  input  logic [DEVW-1:0]               seqDevStat,
  output logic [HALF_W-1:0]             statusOut,
  output logic [CFG_WORDS*REG_W-1:0]    cfgOut
);
  csrStrobes_t str;
  logic [HALF_W-1:0] statusQ;

  dma_csr_ctrl u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .runQ(statusQ[B_RUN]), .pauseQ(statusQ[B_PAUSE]),
    .seqActive(seqActive), .seqStopAck(seqStopAck),
    .seqFlushDone(seqFlushDone), .seqFatal(seqFatal),
    .seqBtValid(seqBtValid), .seqBt(seqBt),
    .seqDevWe(seqDevWe), .seqDevStat(seqDevStat),
    .str(str)
  );

  dma_csr_datapath u_dp (
    .clk(clk), .rst(rst), .str(str),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .statusQ(statusQ), .cfgFlat(cfgOut)
  );

  assign statusOut = statusQ;
endmodule

// File: rtl/dma_chan_csr_chk.sv
`timescale 1ns/1ps
module dma_chan_csr_chk
  import dma_csr_pkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic                        regWe,
  input logic [ADDR_W-1:0]           regAddr,
  input logic [REG_W-1:0]            regWdata,
  input logic [REG_W-1:0]            regRdata,
  input logic                        seqActive,
  input logic                        seqStopAck,
  input logic                        seqFatal,
  input logic                        seqFlushDone,
  input logic [HALF_W-1:0]           statusOut,
  input logic [NUM_CFG*REG_W-1:0]    cfgOut
);
  // R9
  fatal_kills_chk: assert property (@(posedge clk) disable iff (rst)
    seqFatal |=> statusOut[B_DEAD] && !statusOut[B_ACTIVE]);

  // R9
  dead_holds_chk: assert property (@(posedge clk) disable iff (rst)
    statusOut[B_DEAD] && !(regWe && regAddr == W_CTL && regWdata[B_DEAD+HALF_W])
      |=> statusOut[B_DEAD]);

  // R7
  stop_ack_chk: assert property (@(posedge clk) disable iff (rst)
    seqStopAck |=> !statusOut[B_ACTIVE]);

  // R8
  flush_drain_chk: assert property (@(posedge clk) disable iff (rst)
    seqFlushDone |=> !statusOut[B_FLUSH]);

  // R6
  active_track_chk: assert property (@(posedge clk) disable iff (rst)
    statusOut[B_RUN] && !statusOut[B_PAUSE] && !seqStopAck && !seqFatal
      |=> statusOut[B_ACTIVE] == $past(seqActive));

  // R2
  bit9_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !statusOut[9]);

  // R3
  rsvd_read_chk: assert property (@(posedge clk) disable iff (rst)
    (regAddr == 4'd10 || regAddr >= 4'd13) |-> regRdata == '0);

  // R3
  stat_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    regWe && regAddr == W_STAT
      |=> $stable(cfgOut) && $stable(statusOut[B_RUN:B_PAUSE]) && $stable(statusOut[B_WAKE]));
endmodule

bind dma_chan_csr dma_chan_csr_chk u_chk (.*);

// File: tb/dma_chan_csr_bench.sv
`timescale 1ns/1ps
module dma_chan_csr_bench;
  localparam int NCFG = 10;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic seqActive = 0, seqStopAck = 0, seqFlushDone = 0, seqFatal = 0;
  logic seqBtValid = 0, seqBt = 0, seqDevWe = 0;
  logic [7:0] seqDevStat = '0;
  logic [15:0] statusOut;
  logic [NCFG*32-1:0] cfgOut;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;
  string curReq = "R1";

  logic [15:0] mSt;
  logic [31:0] mCfg [NCFG];

  always #4 clk = ~clk;

  dma_chan_csr u_dma_chan_csr (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .seqActive(seqActive), .seqStopAck(seqStopAck),
    .seqFlushDone(seqFlushDone), .seqFatal(seqFatal),
    .seqBtValid(seqBtValid), .seqBt(seqBt),
    .seqDevWe(seqDevWe), .seqDevStat(seqDevStat),
    .statusOut(statusOut), .cfgOut(cfgOut)
  );

  function automatic int cfgIndex(input int a);
    if (a >= 2 && a <= 9) return a - 2;
    if (a == 11) return 8;
    if (a == 12) return 9;
    return -1;
  endfunction

  function automatic logic [31:0] modelRead(input int a);
    if (a == 0 || a == 1) return {16'h0, mSt};
    if (cfgIndex(a) >= 0) return mCfg[cfgIndex(a)];
    return 32'h0;
  endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    logic [15:0] n;
    if (rst) begin
      mSt = '0;
      for (int i = 0; i < NCFG; i++) mCfg[i] = '0;
    end else begin
      n = mSt;
      if (regWe && regAddr == 0)
        for (int i = 0; i < 16; i++) if (regWdata[16+i]) n[i] = regWdata[i];
      if (regWe && cfgIndex(int'(regAddr)) >= 0) mCfg[cfgIndex(int'(regAddr))] = regWdata;
      if (seqDevWe) n[7:0] = seqDevStat;
      if (seqBtValid) n[8] = seqBt;
      if (seqFlushDone) n[13] = 1'b0;
      if (mSt[15] && !mSt[14]) n[10] = seqActive;
      if (seqStopAck) n[10] = 1'b0;
      if (seqFatal) begin n[11] = 1'b1; n[10] = 1'b0; end
      n[9] = 1'b0;
      mSt = n;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [NCFG*32-1:0] expCfg;
    for (int i = 0; i < NCFG; i++) expCfg[i*32 +: 32] = mCfg[i];
    check(statusOut === mSt, curReq, {16'h0, statusOut}, {16'h0, mSt}, "status");
    check(regRdata === modelRead(int'(regAddr)), curReq, regRdata, modelRead(int'(regAddr)), "rdata");
    check(cfgOut === expCfg, curReq, 32'(cfgOut != expCfg), 32'h0, "cfgOut");
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    regWe = 0; regAddr = 4'd1; regWdata = '0;
    seqActive = 0; seqStopAck = 0; seqFlushDone = 0; seqFatal = 0;
    seqBtValid = 0; seqBt = 0; seqDevWe = 0; seqDevStat = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWe = 1; regAddr = a; regWdata = d;
    tick();
    regWe = 0; regWdata = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !finished) begin
      finished = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    curReq = "R1";
    tick();
    check(statusOut == 16'h0, "R1", {16'h0, statusOut}, 32'h0, "reset status");
    check(cfgOut == '0, "R1", 32'(cfgOut != '0), 32'h0, "reset cfg");

    // R2 masked writes
    curReq = "R2";
    wr(0, 32'h8000_8000);
    check(statusOut == 16'h8000, "R2", {16'h0, statusOut}, 32'h8000, "set run");
    wr(0, 32'h00FF_FFFF);
    check(statusOut == 16'h80FF, "R2", {16'h0, statusOut}, 32'h80FF, "partial mask");
    wr(0, 32'h0200_0200);
    check(statusOut[9] == 1'b0, "R2", {31'h0, statusOut[9]}, 32'h0, "bit9");
    wr(0, 32'h10F0_1000);
    check(statusOut == 16'h900F, "R2", {16'h0, statusOut}, 32'h900F, "wake+dev clear");

    // R5 control word readback
    curReq = "R5";
    regAddr = 0; tick();
    check(regRdata == 32'h0000_900F, "R5", regRdata, 32'h900F, "ctl read");

    // R4 configuration words
    curReq = "R4";
    for (int a = 2; a <= 12; a++) if (a != 10) wr(4'(a), 32'hC0DE_0000 | 32'(a * 17));
    for (int a = 2; a <= 12; a++) if (a != 10) begin
      regAddr = 4'(a); tick();
      check(regRdata == (32'hC0DE_0000 | 32'(a * 17)), "R4", regRdata, 32'hC0DE_0000 | 32'(a * 17), "cfg read");
    end
    check(cfgOut[8*32 +: 32] == (32'hC0DE_0000 | 32'(11 * 17)), "R4", cfgOut[8*32 +: 32], 32'hC0DE_0000 | 32'(11 * 17), "slot8");

    // R3 status write and reserved words
    curReq = "R3";
    wr(1, 32'hFFFF_FFFF);
    check(statusOut == 16'h900F, "R3", {16'h0, statusOut}, 32'h900F, "status write ignored");
    for (int a = 13; a <= 15; a++) wr(4'(a), 32'hFFFF_FFFF);
    wr(10, 32'h1234_5678);
    for (int a = 10; a <= 15; a++) if (a == 10 || a >= 13) begin
      regAddr = 4'(a); tick();
      check(regRdata == 32'h0, "R3", regRdata, 32'h0, "reserved read");
    end

    // R6 active tracking
    curReq = "R6";
    seqActive = 1; tick();
    check(statusOut[10] == 1'b1, "R6", {31'h0, statusOut[10]}, 32'h1, "active follows");
    regWe = 1; regAddr = 0; regWdata = 32'h0400_0000; tick(); regWe = 0;
    check(statusOut[10] == 1'b1, "R6", {31'h0, statusOut[10]}, 32'h1, "track beats sw");
    wr(0, 32'h4000_4000); // pause
    seqActive = 0; tick(); tick();
    check(statusOut[10] == 1'b1, "R6", {31'h0, statusOut[10]}, 32'h1, "paused holds");
    wr(0, 32'h4000_0000);
    tick();

    // R7 stop acknowledge
    curReq = "R7";
    seqActive = 1; tick();
    seqStopAck = 1; tick(); seqStopAck = 0; seqActive = 0;
    check(statusOut[10] == 1'b0, "R7", {31'h0, statusOut[10]}, 32'h0, "stop ack");

    // R8 flush drain
    curReq = "R8";
    wr(0, 32'h2000_2000);
    check(statusOut[13] == 1'b1, "R8", {31'h0, statusOut[13]}, 32'h1, "flush set");
    seqFlushDone = 1; tick(); seqFlushDone = 0;
    check(statusOut[13] == 1'b0, "R8", {31'h0, statusOut[13]}, 32'h0, "flush drained");
    regWe = 1; regAddr = 0; regWdata = 32'h2000_2000; seqFlushDone = 1; tick();
    regWe = 0; seqFlushDone = 0;
    check(statusOut[13] == 1'b0, "R8", {31'h0, statusOut[13]}, 32'h0, "drain beats set");

    // R9 fatal error
    curReq = "R9";
    seqActive = 1; tick();
    regWe = 1; regAddr = 0; regWdata = 32'h0800_0000; seqFatal = 1; tick();
    regWe = 0; seqFatal = 0; seqActive = 0;
    check(statusOut[11:10] == 2'b10, "R9", {30'h0, statusOut[11:10]}, 32'h2, "fatal");
    repeat (4) tick();
    check(statusOut[11] == 1'b1, "R9", {31'h0, statusOut[11]}, 32'h1, "dead holds");
    wr(0, 32'h0800_0000);
    check(statusOut[11] == 1'b0, "R9", {31'h0, statusOut[11]}, 32'h0, "dead cleared");

    // R10 sequencer loads beat software
    curReq = "R10";
    regWe = 1; regAddr = 0; regWdata = 32'h01FF_0000;
    seqBtValid = 1; seqBt = 1; seqDevWe = 1; seqDevStat = 8'hA5; tick();
    idle();
    check(statusOut[8:0] == 9'h1A5, "R10", {23'h0, statusOut[8:0]}, 32'h1A5, "bt/dev load");

    // R11 stop handshake
    curReq = "R11";
    wr(0, 32'hA000_A000);
    seqActive = 1; tick();
    wr(0, 32'hA000_0000);
    check(statusOut[15] == 1'b0 && statusOut[8:0] == 9'h1A5, "R11", {16'h0, statusOut}, 32'h05A5, "stop write");
    begin
      int n = 0;
      regAddr = 1;
      while ((regRdata & 32'h2400) != 0 && n < 50) begin
        seqFlushDone = (n == 2);
        seqStopAck = (n == 4);
        tick(); n++;
      end
      seqFlushDone = 0; seqStopAck = 0; seqActive = 0;
      check((regRdata & 32'h2400) == 0, "R11", regRdata & 32'h2400, 32'h0, "stop poll");
    end

    // R12 reset handshake
    curReq = "R12";
    wr(0, 32'hFFFF_FDFF);
    seqFatal = 1; tick(); seqFatal = 0;
    wr(0, 32'hFC00_0000);
    check(statusOut == 16'h01FF, "R12", {16'h0, statusOut}, 32'h01FF, "reset write");

    // R2 mixed traffic
    curReq = "R2";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom();
      regWe = r[0]; regAddr = 4'(r[7:4]); regWdata = $urandom();
      seqActive = r[8]; seqStopAck = (r[11:9] == 0); seqFlushDone = (r[14:12] == 0);
      seqFatal = (r[19:15] == 0); seqBtValid = r[20]; seqBt = r[21];
      seqDevWe = r[22]; seqDevStat = r[30:23];
      tick();
    end
    idle(); tick();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule